// File: doc/BRIEF.md
# MOESI Cache Line Coherence Controller

This block is the coherence engine that sits beside a small private cache. It keeps one of five states for every line it holds (Invalid, Shared, Exclusive, Owned, Modified) together with one data word and the version number received with the line's most recent ownership grant. Local loads, stores and evictions arrive on a request/response port. When an access lacks the permission it needs, the block sends a read-shared request, an ownership request or a write-back on an outgoing valid/ready channel. It then stalls the core until the directory answers.

Messages from the directory arrive on an incoming valid/ready channel: invalidates, forwarded reads and grants. Answers to invalidates and forwarded reads leave on a separate valid/ready response channel. A dirty line can serve forwarded reads straight to the requesting core. In that case it moves to the Owned state and keeps the memory update for later. The core side handles one access at a time, so at most one miss is ever pending. Directory messages are still taken while that miss is pending.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0). No output valid is high and `core_req_ready` is high. A first load to any line therefore issues a read-shared request.
- R2: A load to an Invalid line sends `net_req_kind` 0 (read-shared) for that line. A grant of kind 2 installs the line as Shared, and a grant of kind 3 installs it as Exclusive. The core response then returns the grant's data.
- R3: A load to a line in any valid state answers on the next cycle with the line's data and sends no network request.
- R4: A store to a line in Exclusive or Modified completes with no network request, writes its data and leaves the line Modified. The Exclusive-to-Modified move is silent.
- R5: A store to a line in Shared, Owned or Invalid sends `net_req_kind` 1 (ownership) and stalls until a grant of kind 4. The line then becomes Modified, holding the store data and the grant's version. The core response returns the store data.
- R6: An invalidate (`dir_kind` 0) makes the line Invalid and answers to `dir_src`. The answer is kind 0 (plain acknowledge) if the line was Shared, Exclusive or Invalid. It is kind 1 (acknowledge with data) carrying the line data if the line was Modified or Owned.
- R7: A forwarded read (`dir_kind` 1) to a Modified line sends the data with `rsp_kind` 2 to `dir_src` and moves the line to Owned. An Owned line answers further forwarded reads the same way and stays Owned, with no write-back.
- R8: A forwarded read to an Exclusive line sends the data with `rsp_kind` 2 and moves the line to Shared.
- R9: Evicting a Modified or Owned line sends `net_req_kind` 2 (write-back) with the line data and its stored version, and leaves the line Invalid. Evicting a Shared or Exclusive line is silent. Core op codes are 0 load, 1 store, 2 evict.
- R10: While a miss or write-back is pending, `core_req_ready` is low. Directory messages, including an invalidate to the pending line, are still accepted.
- R11: `net_req_*` and `rsp_*` hold steady while valid and not ready. `dir_ready` is low while a response is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core access valid |
| core_req_ready | output | 1 | Core access accepted |
| core_req_op | input | 2 | 0 load, 1 store, 2 evict |
| core_req_line | input | LW | Line index |
| core_req_wdata | input | DW | Store data |
| core_resp_valid | output | 1 | One-cycle completion pulse |
| core_resp_rdata | output | DW | Load data or store data |
| net_req_valid | output | 1 | Outgoing request valid |
| net_req_ready | input | 1 | Outgoing request accepted |
| net_req_kind | output | 2 | 0 read-shared, 1 ownership, 2 write-back |
| net_req_line | output | LW | Request line |
| net_req_data | output | DW | Write-back data |
| net_req_ver | output | VW | Write-back version |
| dir_valid | input | 1 | Directory message valid |
| dir_ready | output | 1 | Directory message accepted |
| dir_kind | input | 3 | 0 invalidate, 1 forwarded read, 2 grant Shared, 3 grant Exclusive, 4 grant Modified |
| dir_line | input | LW | Message line |
| dir_data | input | DW | Grant data |
| dir_ver | input | VW | Grant version |
| dir_src | input | IDW | Node to answer |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_kind | output | 2 | 0 acknowledge, 1 acknowledge with data, 2 data |
| rsp_line | output | LW | Response line |
| rsp_data | output | DW | Response data |
| rsp_dest | output | IDW | Destination node |

## Verification
The assertions rely on a well-behaved directory. Grants come only for the line of the pending request. No grant arrives unrequested. A forwarded read targets only a line this cache owns or holds exclusively. The stimulus follows those rules: every grant in the bench answers a request the bench has just taken from `net_req_*`. Forwarded reads go only to lines that earlier steps left Modified, Owned or Exclusive. The invalidate sent during a pending ownership miss goes to a line held Shared.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  localparam logic [2:0] ST_I = 3'd0;
  localparam logic [2:0] ST_S = 3'd1;
  localparam logic [2:0] ST_E = 3'd2;
  localparam logic [2:0] ST_O = 3'd3;
  localparam logic [2:0] ST_M = 3'd4;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_EVICT = 2'd2;

  localparam logic [1:0] NQ_GETS = 2'd0;
  localparam logic [1:0] NQ_GETM = 2'd1;
  localparam logic [1:0] NQ_WB   = 2'd2;

  localparam logic [2:0] DM_INV = 3'd0;
  localparam logic [2:0] DM_FWD = 3'd1;
  localparam logic [2:0] DM_GS  = 3'd2;
  localparam logic [2:0] DM_GE  = 3'd3;
  localparam logic [2:0] DM_GM  = 3'd4;

  localparam logic [1:0] RK_ACK  = 2'd0;
  localparam logic [1:0] RK_ACKD = 2'd1;
  localparam logic [1:0] RK_DATA = 2'd2;

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fsm_e;
endpackage

// File: rtl/moesi_line_array.sv
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW = 32,
  parameter int VW = 4,
  localparam int LW = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we_st,
  input  logic          we_dat,
  input  logic          we_ver,
  input  logic [LW-1:0] widx,
  input  logic [2:0]    wst,
  input  logic [DW-1:0] wdat,
  input  logic [VW-1:0] wver,
  output logic [2:0]    st_o  [NLINES],
  output logic [DW-1:0] dat_o [NLINES],
  output logic [VW-1:0] ver_o [NLINES]
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic sel;
    assign sel = (widx == LW'(g));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        st_o[g]  <= ST_I;
        dat_o[g] <= '0;
        ver_o[g] <= '0;
      end else begin
        if (sel && we_st)  st_o[g]  <= wst;
        if (sel && we_dat) dat_o[g] <= wdat;
        if (sel && we_ver) ver_o[g] <= wver;
      end
    end

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_ni)
      st_o[g] <= ST_M);
  end
endmodule

// File: rtl/moesi_snoop_decode.sv
module moesi_snoop_decode
  import moesi_pkg::*;
(
  input  logic [2:0] kind,
  input  logic [2:0] cur_st,
  output logic [2:0] nxt_st,
  output logic       rsp_en,
  output logic [1:0] rsp_kind
);
  always_comb begin
    nxt_st   = cur_st;
    rsp_en   = 1'b0;
    rsp_kind = RK_ACK;
    case (kind)
      DM_INV: begin
        nxt_st   = ST_I;
        rsp_en   = 1'b1;
        rsp_kind = (cur_st == ST_M || cur_st == ST_O) ? RK_ACKD : RK_ACK;
      end
      DM_FWD: begin
        rsp_en = 1'b1;
        case (cur_st)
          ST_M:    begin nxt_st = ST_O; rsp_kind = RK_DATA; end
          ST_O:    rsp_kind = RK_DATA;
          ST_E:    begin nxt_st = ST_S; rsp_kind = RK_DATA; end
          default: rsp_kind = RK_ACK;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW = 32,
  parameter int VW = 4,
  parameter int IDW = 3,
  localparam int LW = $clog2(NLINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           core_req_valid,
  output logic           core_req_ready,
  input  logic [1:0]     core_req_op,
  input  logic [LW-1:0]  core_req_line,
  input  logic [DW-1:0]  core_req_wdata,
  output logic           core_resp_valid,
  output logic [DW-1:0]  core_resp_rdata,
  output logic           net_req_valid,
  input  logic           net_req_ready,
  output logic [1:0]     net_req_kind,
  output logic [LW-1:0]  net_req_line,
  output logic [DW-1:0]  net_req_data,
  output logic [VW-1:0]  net_req_ver,
  input  logic           dir_valid,
  output logic           dir_ready,
  input  logic [2:0]     dir_kind,
  input  logic [LW-1:0]  dir_line,
  input  logic [DW-1:0]  dir_data,
  input  logic [VW-1:0]  dir_ver,
  input  logic [IDW-1:0] dir_src,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [1:0]     rsp_kind,
  output logic [LW-1:0]  rsp_line,
  output logic [DW-1:0]  rsp_data,
  output logic [IDW-1:0] rsp_dest
);
  // reset: asserted at once, released through two flops
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ni, rst_meta} <= 2'b00;
    else        {rst_ni, rst_meta} <= {rst_meta, 1'b1};
  end

  // line storage
  logic          we_st, we_dat, we_ver;
  logic [LW-1:0] widx;
  logic [2:0]    wst;
  logic [DW-1:0] wdat;
  logic [VW-1:0] wver;
  logic [2:0]    st_arr  [NLINES];
  logic [DW-1:0] dat_arr [NLINES];
  logic [VW-1:0] ver_arr [NLINES];

  moesi_line_array #(.NLINES(NLINES), .DW(DW), .VW(VW)) u_lines (
    .clk(clk), .rst_ni(rst_ni), .we_st(we_st), .we_dat(we_dat), .we_ver(we_ver),
    .widx(widx), .wst(wst), .wdat(wdat), .wver(wver),
    .st_o(st_arr), .dat_o(dat_arr), .ver_o(ver_arr)
  );

  // registers
  fsm_e           fsm_q, fsm_d;
  logic [1:0]     pend_op_q;
  logic [LW-1:0]  pend_line_q;
  logic [DW-1:0]  pend_wdata_q;
  logic           nq_valid_q, nq_valid_d, nq_ld;
  logic [1:0]     nq_kind_q, nq_kind_d;
  logic [DW-1:0]  nq_data_q, nq_data_d;
  logic [VW-1:0]  nq_ver_q, nq_ver_d;
  logic [LW-1:0]  nq_line_q;
  logic           cr_valid_q, cr_valid_d, cr_ld;
  logic [DW-1:0]  cr_data_q, cr_data_d;
  logic           rsp_valid_q, rsp_valid_d, rsp_ld;
  logic [1:0]     rsp_kind_q;
  logic [LW-1:0]  rsp_line_q;
  logic [DW-1:0]  rsp_data_q;
  logic [IDW-1:0] rsp_dest_q;
  logic           pend_ld;

  // directory side
  logic       dir_fire, is_snoop, grant_fire, snp_rsp_en;
  logic [2:0] snp_nxt;
  logic [1:0] snp_kind;
  logic [2:0] d_st, c_st;
  logic [DW-1:0] d_dat, c_dat;
  logic [VW-1:0] c_ver;

  assign d_st  = st_arr[dir_line];
  assign d_dat = dat_arr[dir_line];
  assign c_st  = st_arr[core_req_line];
  assign c_dat = dat_arr[core_req_line];
  assign c_ver = ver_arr[core_req_line];

  assign dir_ready  = !rsp_valid_q;
  assign dir_fire   = dir_valid && dir_ready;
  assign is_snoop   = (dir_kind == DM_INV) || (dir_kind == DM_FWD);
  assign grant_fire = dir_fire && (fsm_q == F_WAIT) && (dir_line == pend_line_q) &&
                      (dir_kind == DM_GS || dir_kind == DM_GE || dir_kind == DM_GM);

  moesi_snoop_decode u_snoop (
    .kind(dir_kind), .cur_st(d_st), .nxt_st(snp_nxt),
    .rsp_en(snp_rsp_en), .rsp_kind(snp_kind)
  );

  // core side
  logic core_fire;
  assign core_req_ready = (fsm_q == F_IDLE) && !dir_valid;
  assign core_fire      = core_req_valid && core_req_ready;

  // line write port: directory first, then core
  always_comb begin
    we_st = 1'b0; we_dat = 1'b0; we_ver = 1'b0;
    widx = core_req_line; wst = ST_I; wdat = core_req_wdata; wver = dir_ver;
    if (dir_fire && is_snoop) begin
      we_st = 1'b1; widx = dir_line; wst = snp_nxt;
    end else if (grant_fire) begin
      we_st = 1'b1; we_dat = 1'b1; widx = pend_line_q;
      if (pend_op_q == OP_STORE) begin
        wst = ST_M; wdat = pend_wdata_q; we_ver = 1'b1;
      end else begin
        wst = (dir_kind == DM_GE) ? ST_E : ST_S; wdat = dir_data;
      end
    end else if (core_fire) begin
      if (core_req_op == OP_STORE && (c_st == ST_M || c_st == ST_E)) begin
        we_st = 1'b1; we_dat = 1'b1; wst = ST_M;
      end else if (core_req_op == OP_EVICT) begin
        we_st = 1'b1; wst = ST_I;
      end
    end
  end

  // next state
  always_comb begin
    fsm_d = fsm_q; pend_ld = 1'b0;
    nq_valid_d = nq_valid_q; nq_ld = 1'b0;
    nq_kind_d = NQ_GETS; nq_data_d = c_dat; nq_ver_d = c_ver;
    cr_valid_d = 1'b0; cr_ld = 1'b0; cr_data_d = c_dat;
    rsp_valid_d = rsp_valid_q; rsp_ld = 1'b0;
    if (rsp_valid_q && rsp_ready) rsp_valid_d = 1'b0;
    if (dir_fire && is_snoop && snp_rsp_en) begin
      rsp_valid_d = 1'b1; rsp_ld = 1'b1;
    end
    case (fsm_q)
      F_IDLE: if (core_fire) begin
        pend_ld = 1'b1;
        case (core_req_op)
          OP_LOAD:
            if (c_st != ST_I) begin
              cr_valid_d = 1'b1; cr_ld = 1'b1;
            end else begin
              nq_valid_d = 1'b1; nq_ld = 1'b1; nq_kind_d = NQ_GETS; fsm_d = F_ISSUE;
            end
          OP_STORE:
            if (c_st == ST_M || c_st == ST_E) begin
              cr_valid_d = 1'b1; cr_ld = 1'b1; cr_data_d = core_req_wdata;
            end else begin
              nq_valid_d = 1'b1; nq_ld = 1'b1; nq_kind_d = NQ_GETM; fsm_d = F_ISSUE;
            end
          OP_EVICT:
            if (c_st == ST_M || c_st == ST_O) begin
              nq_valid_d = 1'b1; nq_ld = 1'b1; nq_kind_d = NQ_WB; fsm_d = F_ISSUE;
            end else begin
              cr_valid_d = 1'b1; cr_ld = 1'b1;
            end
          default: begin
            cr_valid_d = 1'b1; cr_ld = 1'b1;
          end
        endcase
      end
      F_ISSUE: if (net_req_ready) begin
        nq_valid_d = 1'b0;
        if (pend_op_q == OP_EVICT) begin
          cr_valid_d = 1'b1; cr_ld = 1'b1; cr_data_d = nq_data_q; fsm_d = F_IDLE;
        end else begin
          fsm_d = F_WAIT;
        end
      end
      F_WAIT: if (grant_fire) begin
        cr_valid_d = 1'b1; cr_ld = 1'b1; fsm_d = F_IDLE;
        cr_data_d = (pend_op_q == OP_STORE) ? pend_wdata_q : dir_data;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q <= F_IDLE; nq_valid_q <= 1'b0; cr_valid_q <= 1'b0; rsp_valid_q <= 1'b0;
      pend_op_q <= OP_LOAD; pend_line_q <= '0; pend_wdata_q <= '0;
      nq_kind_q <= NQ_GETS; nq_line_q <= '0; nq_data_q <= '0; nq_ver_q <= '0;
      cr_data_q <= '0;
      rsp_kind_q <= RK_ACK; rsp_line_q <= '0; rsp_data_q <= '0; rsp_dest_q <= '0;
    end else begin
      fsm_q <= fsm_d; nq_valid_q <= nq_valid_d;
      cr_valid_q <= cr_valid_d; rsp_valid_q <= rsp_valid_d;
      if (pend_ld) begin
        pend_op_q <= core_req_op; pend_line_q <= core_req_line; pend_wdata_q <= core_req_wdata;
      end
      if (nq_ld) begin
        nq_kind_q <= nq_kind_d; nq_line_q <= core_req_line;
        nq_data_q <= nq_data_d; nq_ver_q <= nq_ver_d;
      end
      if (cr_ld) cr_data_q <= cr_data_d;
      if (rsp_ld) begin
        rsp_kind_q <= snp_kind; rsp_line_q <= dir_line;
        rsp_data_q <= d_dat;    rsp_dest_q <= dir_src;
      end
    end
  end

  assign net_req_valid   = nq_valid_q;
  assign net_req_kind    = nq_kind_q;
  assign net_req_line    = nq_line_q;
  assign net_req_data    = nq_data_q;
  assign net_req_ver     = nq_ver_q;
  assign core_resp_valid = cr_valid_q;
  assign core_resp_rdata = cr_data_q;
  assign rsp_valid       = rsp_valid_q;
  assign rsp_kind        = rsp_kind_q;
  assign rsp_line        = rsp_line_q;
  assign rsp_data        = rsp_data_q;
  assign rsp_dest        = rsp_dest_q;

  // assertions
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    net_req_valid && !net_req_ready |=> net_req_valid && $stable(net_req_kind) &&
    $stable(net_req_line) && $stable(net_req_data) && $stable(net_req_ver));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) &&
    $stable(rsp_data) && $stable(rsp_dest));

  assert_inv_clears_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    dir_fire && dir_kind == DM_INV |=> st_arr[$past(dir_line)] == ST_I);

  assert_fwd_m_to_o_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    dir_fire && dir_kind == DM_FWD && d_st == ST_M |=> st_arr[$past(dir_line)] == ST_O);

  assert_fwd_e_to_s_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    dir_fire && dir_kind == DM_FWD && d_st == ST_E |=> st_arr[$past(dir_line)] == ST_S);

  assert_one_miss_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    net_req_valid |-> !core_req_ready);
endmodule

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;
  localparam int NLINES = 4, DW = 32, VW = 4, IDW = 3, LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic core_req_valid = 1'b0, core_req_ready;
  logic [1:0] core_req_op = '0;
  logic [LW-1:0] core_req_line = '0;
  logic [DW-1:0] core_req_wdata = '0;
  logic core_resp_valid;
  logic [DW-1:0] core_resp_rdata;
  logic net_req_valid, net_req_ready = 1'b0;
  logic [1:0] net_req_kind;
  logic [LW-1:0] net_req_line;
  logic [DW-1:0] net_req_data;
  logic [VW-1:0] net_req_ver;
  logic dir_valid = 1'b0, dir_ready;
  logic [2:0] dir_kind = '0;
  logic [LW-1:0] dir_line = '0;
  logic [DW-1:0] dir_data = '0;
  logic [VW-1:0] dir_ver = '0;
  logic [IDW-1:0] dir_src = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [1:0] rsp_kind;
  logic [LW-1:0] rsp_line;
  logic [DW-1:0] rsp_data;
  logic [IDW-1:0] rsp_dest;

  moesi_line_ctrl #(.NLINES(NLINES), .DW(DW), .VW(VW), .IDW(IDW)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit got_resp = 1'b0;
  logic [DW-1:0] got_data = '0;

  always @(posedge clk) if (core_resp_valid) begin
    got_resp <= 1'b1; got_data <= core_resp_rdata;
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic core_issue(input logic [1:0] op, input logic [LW-1:0] ln, input logic [DW-1:0] wd);
    @(negedge clk);
    got_resp = 1'b0;
    core_req_valid = 1'b1; core_req_op = op; core_req_line = ln; core_req_wdata = wd;
    while (!core_req_ready) @(negedge clk);
    @(posedge clk); #1 core_req_valid = 1'b0;
  endtask

  task automatic wait_resp(input string rq, input logic [DW-1:0] exp);
    for (int i = 0; i < 40 && !got_resp; i++) @(negedge clk);
    chk(rq, "core response seen", got_resp, 1);
    chk(rq, "core response data", got_data, exp);
  endtask

  task automatic take_req(input string rq, input logic [1:0] k, input logic [LW-1:0] ln,
                          input bit chk_dv, input logic [DW-1:0] d, input logic [VW-1:0] v, input int hold);
    for (int i = 0; i < 40 && !net_req_valid; i++) @(negedge clk);
    chk(rq, "net request valid", net_req_valid, 1);
    chk(rq, "net request kind", net_req_kind, k);
    chk(rq, "net request line", net_req_line, ln);
    if (chk_dv) begin
      chk(rq, "net request data", net_req_data, d);
      chk(rq, "net request version", net_req_ver, v);
    end
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(rq, "request held valid", net_req_valid, 1);
      chk(rq, "request held kind", net_req_kind, k);
      if (chk_dv) chk(rq, "request held data", net_req_data, d);
    end
    @(negedge clk); net_req_ready = 1'b1;
    @(posedge clk); #1 net_req_ready = 1'b0;
  endtask

  task automatic send_dir(input logic [2:0] k, input logic [LW-1:0] ln, input logic [DW-1:0] d,
                          input logic [VW-1:0] v, input logic [IDW-1:0] s);
    @(negedge clk);
    dir_valid = 1'b1; dir_kind = k; dir_line = ln; dir_data = d; dir_ver = v; dir_src = s;
    while (!dir_ready) @(negedge clk);
    @(posedge clk); #1 dir_valid = 1'b0;
  endtask

  task automatic take_rsp(input string rq, input logic [1:0] k, input logic [LW-1:0] ln,
                          input bit chk_d, input logic [DW-1:0] d, input logic [IDW-1:0] dst);
    for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
    chk(rq, "response valid", rsp_valid, 1);
    chk(rq, "response kind", rsp_kind, k);
    chk(rq, "response line", rsp_line, ln);
    chk(rq, "response dest", rsp_dest, dst);
    if (chk_d) chk(rq, "response data", rsp_data, d);
    @(negedge clk); rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
  endtask

  task automatic expect_no_req(input string rq);
    bit seen = 1'b0;
    repeat (4) begin @(negedge clk); if (net_req_valid) seen = 1'b1; end
    chk(rq, "no network request", seen, 0);
  endtask

  // scenarios
  task automatic t_reset;
    chk("R1", "net_req_valid after reset", net_req_valid, 0);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R1", "core_resp_valid after reset", core_resp_valid, 0);
    chk("R1", "core_req_ready after reset", core_req_ready, 1);
  endtask

  task automatic t_load_miss_shared;
    core_issue(2'd0, 2'd0, '0);
    take_req("R1", 2'd0, 2'd0, 1'b0, '0, '0, 0);
    @(negedge clk);
    chk("R10", "ready low while load miss waits", core_req_ready, 0);
    send_dir(3'd2, 2'd0, 32'h11, 4'd0, 3'd7);
    wait_resp("R2", 32'h11);
  endtask

  task automatic t_load_hit;
    core_issue(2'd0, 2'd0, '0);
    wait_resp("R3", 32'h11);
    expect_no_req("R3");
  endtask

  task automatic t_store_upgrade_with_inv;
    core_issue(2'd1, 2'd0, 32'h22);
    take_req("R5", 2'd1, 2'd0, 1'b0, '0, '0, 0);
    @(negedge clk);
    chk("R10", "ready low while ownership pending", core_req_ready, 0);
    send_dir(3'd0, 2'd0, '0, '0, 3'd7);
    take_rsp("R10", 2'd0, 2'd0, 1'b0, '0, 3'd7);
    chk("R5", "no completion before grant", got_resp, 0);
    send_dir(3'd4, 2'd0, 32'h99, 4'd5, 3'd7);
    wait_resp("R5", 32'h22);
  endtask

  task automatic t_fwd_owned;
    send_dir(3'd1, 2'd0, '0, '0, 3'd3);
    take_rsp("R7", 2'd2, 2'd0, 1'b1, 32'h22, 3'd3);
    send_dir(3'd1, 2'd0, '0, '0, 3'd4);
    take_rsp("R7", 2'd2, 2'd0, 1'b1, 32'h22, 3'd4);
    expect_no_req("R7");
  endtask

  task automatic t_evict_owned;
    core_issue(2'd2, 2'd0, '0);
    take_req("R9", 2'd2, 2'd0, 1'b1, 32'h22, 4'd5, 3);
    wait_resp("R9", 32'h22);
    core_issue(2'd0, 2'd0, '0);
    take_req("R9", 2'd0, 2'd0, 1'b0, '0, '0, 0);
    send_dir(3'd3, 2'd0, 32'h33, 4'd0, 3'd7);
    wait_resp("R2", 32'h33);
  endtask

  task automatic t_store_hit_exclusive;
    core_issue(2'd1, 2'd0, 32'h44);
    wait_resp("R4", 32'h44);
    expect_no_req("R4");
    send_dir(3'd0, 2'd0, '0, '0, 3'd6);
    take_rsp("R4", 2'd1, 2'd0, 1'b1, 32'h44, 3'd6);
    core_issue(2'd0, 2'd0, '0);
    take_req("R6", 2'd0, 2'd0, 1'b0, '0, '0, 0);
    send_dir(3'd2, 2'd0, 32'h45, 4'd0, 3'd7);
    wait_resp("R6", 32'h45);
  endtask

  task automatic t_fwd_exclusive;
    core_issue(2'd0, 2'd2, '0);
    take_req("R2", 2'd0, 2'd2, 1'b0, '0, '0, 0);
    send_dir(3'd3, 2'd2, 32'h55, 4'd0, 3'd7);
    wait_resp("R2", 32'h55);
    send_dir(3'd1, 2'd2, '0, '0, 3'd6);
    take_rsp("R8", 2'd2, 2'd2, 1'b1, 32'h55, 3'd6);
    core_issue(2'd1, 2'd2, 32'h66);
    take_req("R8", 2'd1, 2'd2, 1'b0, '0, '0, 0);
    send_dir(3'd4, 2'd2, 32'h55, 4'd7, 3'd7);
    wait_resp("R5", 32'h66);
    core_issue(2'd2, 2'd2, '0);
    take_req("R9", 2'd2, 2'd2, 1'b1, 32'h66, 4'd7, 0);
    wait_resp("R9", 32'h66);
  endtask

  task automatic t_silent_evict;
    core_issue(2'd0, 2'd3, '0);
    take_req("R2", 2'd0, 2'd3, 1'b0, '0, '0, 0);
    send_dir(3'd2, 2'd3, 32'h77, 4'd0, 3'd7);
    wait_resp("R2", 32'h77);
    core_issue(2'd2, 2'd3, '0);
    for (int i = 0; i < 40 && !got_resp; i++) @(negedge clk);
    chk("R9", "silent evict completes", got_resp, 1);
    expect_no_req("R9");
    core_issue(2'd0, 2'd3, '0);
    take_req("R9", 2'd0, 2'd3, 1'b0, '0, '0, 0);
    send_dir(3'd2, 2'd3, 32'h78, 4'd0, 3'd7);
    wait_resp("R9", 32'h78);
  endtask

  task automatic t_dir_backpressure;
    core_issue(2'd1, 2'd1, 32'h88);
    take_req("R5", 2'd1, 2'd1, 1'b0, '0, '0, 0);
    send_dir(3'd4, 2'd1, 32'h0, 4'd2, 3'd7);
    wait_resp("R5", 32'h88);
    send_dir(3'd1, 2'd1, '0, '0, 3'd5);
    @(negedge clk);
    chk("R11", "dir_ready low with response waiting", dir_ready, 0);
    repeat (2) @(negedge clk);
    chk("R11", "response held", rsp_valid, 1);
    take_rsp("R7", 2'd2, 2'd1, 1'b1, 32'h88, 3'd5);
    @(negedge clk);
    chk("R11", "dir_ready back after response", dir_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_load_miss_shared;
    t_load_hit;
    t_store_upgrade_with_inv;
    t_fwd_owned;
    t_evict_owned;
    t_store_hit_exclusive;
    t_fwd_exclusive;
    t_silent_evict;
    t_dir_backpressure;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule